// File: doc/BRIEF.md
# Three-Level Control Input Qualifier

This block sits behind the comparators of a power stage's control inputs. It takes two inputs that each have three levels. One is a pulse command and one is a mode select. Each input arrives as a pair of comparator flags: one flag says the input is above the upper threshold, the other says it is below the lower threshold. With neither flag set, the input sits in the middle band. With both flags set, the sample is contradictory.

For each input, the block filters the middle level in time. A middle level is accepted only after it has been present without a break for a window of clock cycles. High and low levels are accepted at the next clock edge. From the two qualified levels the block derives a registered pulse command and an operating mode: forced continuous, diode emulation or standby. It also drives a flag that disables the sense outputs during standby. A wake timer holds off the current-sense-ready flag for a fixed time after the block leaves standby. All windows are counted in cycles of one clock and set by parameters: 50 for the pulse input, 2000 for the mode input and 20000 for the wake time.

Top module: `tlvl_cmd_qual`

## Requirements
- R1: While reset is asserted and after it is released with both inputs in the middle band, `pwm_cmd` is 2'b10 (tri-state), `mode` is 2'b10 (standby), `sense_off` is 1 and `cs_active` is 0.
- R2: A flag pair of above=1/below=0 is a high sample and above=0/below=1 is a low sample. On the pulse input, a high sample makes `pwm_cmd` 2'b01 and a low sample makes it 2'b00, both visible after the next rising clock edge.
- R3: The pulse input reads as tri-state (`pwm_cmd` = 2'b10) only after PWM_MID_CYC consecutive middle-band samples (both flags 0). A high or low sample before then restarts the count, and `pwm_cmd` keeps its previous value.
- R4: A sample with both flags set is invalid. It changes neither the qualified level nor the middle-band count, so middle samples on either side of it add up.
- R5: After SYNC_MID_CYC consecutive middle-band samples on the mode input, `mode` becomes 2'b10 (standby) and `sense_off` becomes 1.
- R6: A high level on the mode input gives `mode` 2'b00 (forced continuous), and a low level gives 2'b01 (diode emulation). Either takes effect at the next edge.
- R7: A qualified tri-state on the pulse input gives `mode` 2'b01 (diode emulation) when the mode input is high. Standby takes precedence over it.
- R8: `cs_active` rises exactly WAKE_CYC clock edges after `mode` leaves standby. It clears at the first edge after standby is entered again.
- R9: A middle-band run on the mode input that is shorter than SYNC_MID_CYC does not enter standby. A high or low sample restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single synchronous clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_above_hi | input | 1 | Pulse input above the upper threshold |
| pwm_below_lo | input | 1 | Pulse input below the lower threshold |
| sync_above_hi | input | 1 | Mode input above the upper threshold |
| sync_below_lo | input | 1 | Mode input below the lower threshold |
| pwm_cmd | output | 2 | Qualified pulse command: 00 low, 01 high, 10 tri-state |
| mode | output | 2 | Operating mode: 00 forced continuous, 01 diode emulation, 10 standby |
| sense_off | output | 1 | Sense and temperature/fault outputs disabled (standby) |
| cs_active | output | 1 | Current sense awake after the wake time |

## Verification
A middle-band counter that is off by one cycle, or that clears on an invalid sample, shows up at `pwm_cmd` or `mode` one edge early or late at the end of the window. The corner vectors sample on both sides of that edge. A wrong mode decode appears on `mode` at the first edge after the input change. A wake counter that does not clear, or that ends one cycle early, appears on `cs_active` within WAKE_CYC cycles of leaving standby.

// File: rtl/tlq_pkg.sv
package tlq_pkg;
  typedef enum logic [1:0] {
    LV_LO  = 2'b00,
    LV_HI  = 2'b01,
    LV_MID = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    MD_FCCM  = 2'b00,
    MD_DIODE = 2'b01,
    MD_STBY  = 2'b10
  } mode_e;
endpackage

// File: rtl/tlq_level_filter.sv
module tlq_level_filter
  import tlq_pkg::*;
#(
  parameter int WIN = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi,
  input  logic below_lo,
  output lvl_e lvl_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  lvl_e          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    case ({above_hi, below_lo})
      2'b10: begin
        lvl_d = LV_HI;
        cnt_d = '0;
      end
      2'b01: begin
        lvl_d = LV_LO;
        cnt_d = '0;
      end
      2'b00: begin
        if (lvl_q != LV_MID) begin
          if (cnt_q == LAST) begin
            lvl_d = LV_MID;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        lvl_d = lvl_q;
        cnt_d = cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LV_MID;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_o = lvl_q;

  AST_HI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (above_hi && !below_lo) |=> (lvl_q == LV_HI)); // R2
  AST_LO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_hi && below_lo) |=> (lvl_q == LV_LO)); // R2
  AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (above_hi && below_lo) |=> ($stable(lvl_q) && $stable(cnt_q))); // R4
  AST_MID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LV_MID && $past(lvl_q) != LV_MID) |-> ($past(cnt_q) == LAST && !$past(above_hi) && !$past(below_lo))); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/tlq_mode_decode.sv
module tlq_mode_decode
  import tlq_pkg::*;
(
  input  lvl_e  pwm_lvl,
  input  lvl_e  sync_lvl,
  output mode_e mode_o
);
  always_comb begin
    if (sync_lvl == LV_MID)
      mode_o = MD_STBY;
    else if (sync_lvl == LV_LO || pwm_lvl == LV_MID)
      mode_o = MD_DIODE;
    else
      mode_o = MD_FCCM;
  end
endmodule

// File: rtl/tlq_wake_timer.sv
module tlq_wake_timer #(
  parameter int WAKE = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  output logic active
);
  localparam int CW = $clog2(WAKE + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (standby) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (!act_q) begin
      if (cnt_q == LAST) act_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;

  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !act_q); // R8
  AST_WAKE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(cnt_q) == LAST && !$past(standby))); // R8
endmodule

// File: rtl/tlvl_cmd_qual.sv
module tlvl_cmd_qual
  import tlq_pkg::*;
#(
  parameter int PWM_MID_CYC  = 50,
  parameter int SYNC_MID_CYC = 2000,
  parameter int WAKE_CYC     = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_above_hi,
  input  logic       pwm_below_lo,
  input  logic       sync_above_hi,
  input  logic       sync_below_lo,
  output logic [1:0] pwm_cmd,
  output logic [1:0] mode,
  output logic       sense_off,
  output logic       cs_active
);
  localparam int NIN = 2;

  logic [NIN-1:0] hi_flags, lo_flags;
  lvl_e           lvl [NIN];
  mode_e          mode_w;

  assign hi_flags = {sync_above_hi, pwm_above_hi};
  assign lo_flags = {sync_below_lo, pwm_below_lo};

  for (genvar g = 0; g < NIN; g++) begin : g_filt
    localparam int W = (g == 0) ? PWM_MID_CYC : SYNC_MID_CYC;
    tlq_level_filter #(.WIN(W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .above_hi (hi_flags[g]),
      .below_lo (lo_flags[g]),
      .lvl_o    (lvl[g])
    );
  end

  tlq_mode_decode u_dec (
    .pwm_lvl  (lvl[0]),
    .sync_lvl (lvl[1]),
    .mode_o   (mode_w)
  );

  tlq_wake_timer #(.WAKE(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .standby (mode_w == MD_STBY),
    .active  (cs_active)
  );

  assign pwm_cmd   = lvl[0];
  assign mode      = mode_w;
  assign sense_off = (mode_w == MD_STBY);

  AST_STBY_ONLY_ON_MID: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != MD_STBY && mode == MD_STBY) |-> (!$past(sync_above_hi) && !$past(sync_below_lo))); // R5
endmodule

// File: tb/tlvl_cmd_qual_test.sv
module tlvl_cmd_qual_test;
  localparam int PM = 5;
  localparam int SM = 20;
  localparam int WK = 40;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa, pb, sa, sb;
  logic [1:0] pwm_cmd, mode;
  logic sense_off, cs_active;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tlvl_cmd_qual #(.PWM_MID_CYC(PM), .SYNC_MID_CYC(SM), .WAKE_CYC(WK)) uut (
    .clk(clk), .rst_n(rst_n),
    .pwm_above_hi(pa), .pwm_below_lo(pb),
    .sync_above_hi(sa), .sync_below_lo(sb),
    .pwm_cmd(pwm_cmd), .mode(mode), .sense_off(sense_off), .cs_active(cs_active)
  );

  // drive code: 0 low, 1 high, 2 middle, 3 invalid (both flags)
  // fields: pwm drive, sync drive, edges, expected pwm_cmd, expected mode
  localparam logic [15:0] VEC [NV] = '{
    {2'd1, 2'd1, 8'd1,  2'b01, 2'b00},  // R2 R6 high/high
    {2'd0, 2'd1, 8'd1,  2'b00, 2'b00},  // R2 low
    {2'd2, 2'd1, 8'd4,  2'b00, 2'b00},  // R3 window not yet full
    {2'd2, 2'd1, 8'd1,  2'b10, 2'b01},  // R3 R7 tri-state -> diode
    {2'd1, 2'd0, 8'd1,  2'b01, 2'b01},  // R6 sync low -> diode
    {2'd1, 2'd1, 8'd1,  2'b01, 2'b00},  // R6 sync high -> forced
    {2'd2, 2'd1, 8'd3,  2'b01, 2'b00},  // R3 partial run
    {2'd0, 2'd1, 8'd1,  2'b00, 2'b00},  // R3 excursion
    {2'd2, 2'd1, 8'd4,  2'b00, 2'b00},  // R3 restarted count
    {2'd2, 2'd1, 8'd1,  2'b10, 2'b01},  // R3 R7
    {2'd2, 2'd2, 8'd19, 2'b10, 2'b01},  // R5 sync window not full
    {2'd2, 2'd2, 8'd1,  2'b10, 2'b10},  // R5 R7 standby wins
    {2'd1, 2'd2, 8'd1,  2'b01, 2'b10},  // R2 in standby
    {2'd1, 2'd0, 8'd1,  2'b01, 2'b01}   // R6 leave standby
  };

  task automatic drive(input logic [1:0] p, input logic [1:0] s);
    pa = (p == 2'd1) || (p == 2'd3);
    pb = (p == 2'd0) || (p == 2'd3);
    sa = (s == 2'd1) || (s == 2'd3);
    sb = (s == 2'd0) || (s == 2'd3);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [1:0] cur_p;
  logic [1:0] cur_s;

  initial begin
    drive(2'd2, 2'd2);
    cur_p = 2'd2;
    cur_s = 2'd2;
    repeat (3) @(negedge clk);
    chk("R1 pwm_cmd in reset", pwm_cmd, 2'b10);
    chk("R1 mode in reset", mode, 2'b10);
    chk("R1 sense_off in reset", {1'b0, sense_off}, 2'b01);
    chk("R1 cs_active in reset", {1'b0, cs_active}, 2'b00);
    rst_n = 1'b1;
    tick(5);
    chk("R1 pwm_cmd after release", pwm_cmd, 2'b10);
    chk("R1 mode after release", mode, 2'b10);

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][15:14], VEC[v][13:12]);
      cur_s = VEC[v][13:12];
      tick(int'(VEC[v][11:4]));
      chk($sformatf("R2/R3/R7 vector %0d pwm_cmd", v), pwm_cmd, VEC[v][3:2]);
      chk($sformatf("R5/R6/R7 vector %0d mode", v), mode, VEC[v][1:0]);
    end

    // R4: invalid samples hold both level and count
    drive(2'd1, 2'd1); tick(1);
    drive(2'd0, 2'd1); tick(1);
    drive(2'd2, 2'd1); tick(3);
    drive(2'd3, 2'd1); tick(4);
    chk("R4 invalid holds low", pwm_cmd, 2'b00);
    drive(2'd2, 2'd1); tick(1);
    chk("R4 count held, not yet mid", pwm_cmd, 2'b00);
    tick(1);
    chk("R4 count resumed to mid", pwm_cmd, 2'b10);
    drive(2'd1, 2'd1); tick(1);
    drive(2'd3, 2'd1); tick(3);
    chk("R4 invalid holds high", pwm_cmd, 2'b01);

    // R9: short middle runs on sync
    drive(2'd1, 2'd2); tick(19);
    chk("R9 short sync run", mode, 2'b00);
    drive(2'd1, 2'd1); tick(1);
    drive(2'd1, 2'd2); tick(19);
    chk("R9 restarted sync run", mode, 2'b00);
    tick(1);
    chk("R5 standby after full window", mode, 2'b10);
    chk("R5 sense_off in standby", {1'b0, sense_off}, 2'b01);
    tick(1);
    chk("R8 cs_active cleared in standby", {1'b0, cs_active}, 2'b00);

    // R8: wake time
    drive(2'd1, 2'd1); tick(1);
    chk("R6 leave standby forced", mode, 2'b00);
    chk("R5 sense_off released", {1'b0, sense_off}, 2'b00);
    tick(WK - 1);
    chk("R8 cs_active one edge early", {1'b0, cs_active}, 2'b00);
    tick(1);
    chk("R8 cs_active after wake time", {1'b0, cs_active}, 2'b01);
    drive(2'd1, 2'd2); tick(SM);
    chk("R5 standby again", mode, 2'b10);
    tick(1);
    chk("R8 cs_active cleared again", {1'b0, cs_active}, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule